// File: doc/BRIEF.md
# One-wire ROM identifier builder

This block assembles the 64-bit identifier that a one-wire slave sends to its bus master. The low byte is a fixed family code and the next 32 bits are a serial number taken from an input. A fixed 16-bit constant follows. The top byte is a CRC-8 over the 56 bits below it. Put together this way, the word can be shifted out least-significant bit first with no further rearrangement.

The CRC is computed one bit per clock. The 56 payload bits pass through a shift register into a one-byte CRC engine, so the block needs no wide XOR tree. A single-cycle start strobe captures the serial input and begins a computation. The valid flag rises when the word is complete and stays up until the next strobe.

Top module: `rom_id_builder`

## Requirements
- R1: After reset is released and before any start strobe, valid_o is 0.
- R2: When valid_o is 1, rom_o[7:0] equals the FAMILY parameter (default 0xCF).
- R3: When valid_o is 1, rom_o[39:8] equals the value serial_i held at the clock edge that sampled start_i high. Changes to serial_i after that edge have no effect on the result.
- R4: When valid_o is 1, rom_o[55:40] equals the SER_HI parameter (default 0xCF1D).
- R5: When valid_o is 1, rom_o[63:56] holds a CRC-8 over rom_o[55:0], taken bit 0 first. The register starts at 0x00. For each bit, feedback = bit XOR register[0]; the register shifts right by one, and when feedback is 1 it is XORed with 0x8C.
- R6: valid_o rises at the 56th rising clock edge after the edge that sampled start_i high, and at no earlier edge.
- R7: valid_o is 0 from the edge that samples start_i high until the result is complete.
- R8: A start strobe during a computation abandons it. The new serial value is captured, and the result is due 56 edges after the new strobe.
- R9: While valid_o is 1 and start_i stays low, valid_o stays 1 and rom_o does not change.
- R10: With default parameters, serial 0x12345678 gives rom_o = 0x8FCF1D12345678CF, and serial 0xCAFEBABE gives rom_o = 0x47CF1DCAFEBABECF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; captures serial_i and (re)starts the computation |
| serial_i | input | 32 | Serial-number bits placed at rom_o[39:8] |
| valid_o | output | 1 | Result complete and stable |
| rom_o | output | 64 | Assembled identifier, LSB-first transmit order |

## Verification
Each result is due at the 56th rising edge after the edge that samples the strobe. The bench records that edge's cycle number next to the expected word in its scoreboard. The monitor samples on falling edges and compares the measured latency with 56 when valid_o rises. Checks that valid_o stays low are placed at falling edges inside the 56-cycle window. The hold checks run ten cycles after completion. An abandoned computation pushes no entry, so any word produced for it shows up as a mismatch.

// File: rtl/rom_id_pkg.sv
`timescale 1ns/1ps
package rom_id_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  localparam logic [7:0] CRC8_POLY_REFL = 8'h8C;
endpackage

// File: rtl/rom_id_seq.sv
`timescale 1ns/1ps
module rom_id_seq
  import rom_id_pkg::*;
#(
  parameter int PAY_W = 56
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic shift_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(PAY_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAY_W - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (start_i) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else if (st_q == ST_RUN) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) st_q <= ST_DONE;
    end
  end

  // start wins over an in-flight shift
  assign load_o  = start_i;
  assign shift_o = (st_q == ST_RUN) && !start_i;
  assign done_o  = (st_q == ST_DONE);
endmodule

// File: rtl/rom_id_field.sv
`timescale 1ns/1ps
module rom_id_field #(
  parameter int              FAM_W  = 8,
  parameter int              LO_W   = 32,
  parameter int              HI_W   = 16,
  parameter logic [FAM_W-1:0] FAMILY = 8'hCF,
  parameter logic [HI_W-1:0]  SER_HI = 16'hCF1D,
  localparam int             PAY_W  = FAM_W + LO_W + HI_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [LO_W-1:0]  serial_i,
  output logic [PAY_W-1:0] payload_o,
  output logic             bit_o
);
  logic [LO_W-1:0]  ser_q;
  logic [PAY_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      ser_q <= serial_i;
      sh_q  <= {SER_HI, serial_i, FAMILY};
    end else if (shift_i) begin
      sh_q  <= {1'b0, sh_q[PAY_W-1:1]};
    end
  end

  assign payload_o = {SER_HI, ser_q, FAMILY};
  assign bit_o     = sh_q[0];
endmodule

// File: rtl/rom_id_crc.sv
`timescale 1ns/1ps
module rom_id_crc #(
  parameter int               CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h8C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  always_comb begin
    fb    = bit_i ^ crc_q[0];
    crc_d = {1'b0, crc_q[CRC_W-1:1]};
    if (fb) crc_d = crc_d ^ POLY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rom_id_builder.sv
`timescale 1ns/1ps
module rom_id_builder
  import rom_id_pkg::*;
#(
  parameter int               FAM_W    = 8,
  parameter int               LO_W     = 32,
  parameter int               HI_W     = 16,
  parameter int               CRC_W    = 8,
  parameter logic [FAM_W-1:0] FAMILY   = 8'hCF,
  parameter logic [HI_W-1:0]  SER_HI   = 16'hCF1D,
  parameter logic [CRC_W-1:0] CRC_POLY = CRC8_POLY_REFL,
  localparam int              PAY_W    = FAM_W + LO_W + HI_W,
  localparam int              ROM_W    = PAY_W + CRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LO_W-1:0]  serial_i,
  output logic             valid_o,
  output logic [ROM_W-1:0] rom_o
);
  logic             load, shift, bit_s;
  logic [PAY_W-1:0] payload;
  logic [CRC_W-1:0] crc;

  rom_id_seq #(.PAY_W(PAY_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .shift_o (shift),
    .done_o  (valid_o)
  );

  rom_id_field #(
    .FAM_W  (FAM_W),
    .LO_W   (LO_W),
    .HI_W   (HI_W),
    .FAMILY (FAMILY),
    .SER_HI (SER_HI)
  ) u_field (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .shift_i   (shift),
    .serial_i  (serial_i),
    .payload_o (payload),
    .bit_o     (bit_s)
  );

  rom_id_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .en_i    (shift),
    .bit_i   (bit_s),
    .crc_o   (crc)
  );

  assign rom_o = {crc, payload};
endmodule

// File: rtl/rom_id_builder_chk.sv
`timescale 1ns/1ps
module rom_id_builder_chk #(
  parameter int               FAM_W  = 8,
  parameter int               LO_W   = 32,
  parameter int               HI_W   = 16,
  parameter int               CRC_W  = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'hCF,
  parameter logic [HI_W-1:0]  SER_HI = 16'hCF1D,
  localparam int              PAY_W  = FAM_W + LO_W + HI_W,
  localparam int              ROM_W  = PAY_W + CRC_W,
  localparam int              CYC_W  = $clog2(PAY_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LO_W-1:0]  serial_i,
  input logic             valid_o,
  input logic [ROM_W-1:0] rom_o
);
  logic [CYC_W-1:0] cyc_q;
  logic [LO_W-1:0]  ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= CYC_W'(PAY_W);
      ser_q <= '0;
    end else if (start_i) begin
      cyc_q <= '0;
      ser_q <= serial_i;
    end else if (cyc_q < CYC_W'(PAY_W)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  p_family_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rom_o[FAM_W-1:0] == FAMILY);

  p_serial_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rom_o[FAM_W+LO_W-1:FAM_W] == ser_q);

  p_ser_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rom_o[PAY_W-1:FAM_W+LO_W] == SER_HI);

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> cyc_q == CYC_W'(PAY_W));

  p_busy_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < CYC_W'(PAY_W)) |-> !valid_o);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (valid_o && $stable(rom_o)));
endmodule

bind rom_id_builder rom_id_builder_chk #(
  .FAM_W  (FAM_W),
  .LO_W   (LO_W),
  .HI_W   (HI_W),
  .CRC_W  (CRC_W),
  .FAMILY (FAMILY),
  .SER_HI (SER_HI)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .serial_i (serial_i),
  .valid_o  (valid_o),
  .rom_o    (rom_o)
);

// File: tb/rom_id_builder_test.sv
`timescale 1ns/1ps
module rom_id_builder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] serial_i = '0;
  logic        valid_o;
  logic [63:0] rom_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit prev_v = 1'b0;
  bit done_f = 1'b0;

  logic [63:0] exp_q[$];
  int          st_q[$];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  rom_id_builder uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .serial_i (serial_i),
    .valid_o  (valid_o),
    .rom_o    (rom_o)
  );

  function automatic logic [63:0] model(input logic [31:0] s);
    logic [55:0] p;
    logic [7:0]  c;
    logic        fb;
    p = {16'hCF1D, s, 8'hCF};
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = p[i] ^ c[0];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return {c, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: strobe start for one cycle, optionally push expectation
  task automatic kick(input logic [31:0] s, input bit expect_it);
    @(negedge clk_i);
    start_i  = 1'b1;
    serial_i = s;
    if (expect_it) begin
      exp_q.push_back(model(s));
      st_q.push_back(cyc + 1);
    end
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o && !prev_v) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected result", rom_o, 64'h0);
      end else begin
        logic [63:0] e;
        int          s;
        e = exp_q.pop_front();
        s = st_q.pop_front();
        chk(rom_o[7:0]   == e[7:0],   "R2 family",  rom_o, e);
        chk(rom_o[39:8]  == e[39:8],  "R3 serial",  rom_o, e);
        chk(rom_o[55:40] == e[55:40], "R4 ser_hi",  rom_o, e);
        chk(rom_o[63:56] == e[63:56], "R5 crc",     rom_o, e);
        chk(cyc - s == 56, "R6 latency", 64'(cyc - s), 64'd56);
      end
    end
    prev_v = valid_o;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 reset valid", 64'(valid_o), 64'd0);

    kick(32'h12345678, 1'b1);
    repeat (30) @(negedge clk_i);
    chk(valid_o == 1'b0, "R7 busy valid", 64'(valid_o), 64'd0);
    wait_done();
    chk(rom_o == 64'h8FCF1D12345678CF, "R10 vector 12345678", rom_o, 64'h8FCF1D12345678CF);

    // R3: serial_i changes mid-run
    kick(32'hCAFEBABE, 1'b1);
    repeat (5) @(negedge clk_i);
    serial_i = 32'h0;
    chk(valid_o == 1'b0, "R7 busy valid early", 64'(valid_o), 64'd0);
    wait_done();
    chk(rom_o == 64'h47CF1DCAFEBABECF, "R10 vector CAFEBABE", rom_o, 64'h47CF1DCAFEBABECF);

    // R9 hold
    held = rom_o;
    serial_i = 32'h5555AAAA;
    repeat (10) @(negedge clk_i);
    chk(valid_o == 1'b1, "R9 valid held", 64'(valid_o), 64'd1);
    chk(rom_o == held, "R9 rom held", rom_o, held);

    // R8 restart mid-run
    kick(32'h11111111, 1'b0);
    repeat (20) @(negedge clk_i);
    chk(valid_o == 1'b0, "R8 valid during aborted run", 64'(valid_o), 64'd0);
    kick(32'hA5A5A5A5, 1'b1);
    wait_done();

    kick(32'h00000000, 1'b1);
    wait_done();
    kick(32'hFFFFFFFF, 1'b1);
    wait_done();
    kick(32'h80000001, 1'b1);
    wait_done();

    // back-to-back: restart right when valid
    kick(32'hDEADBEEF, 1'b1);
    wait_done();
    chk(exp_q.size() == 0, "R6 scoreboard drained", 64'(exp_q.size()), 64'd0);

    done_f = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done_f) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule